// File: doc/BRIEF.md
# Dimension-Routed Circuit Switch

This block joins one local port and a parameterised number of external link ports. Each input carries a stream of tokens, and each token is a data word plus a control flag. The first token of a stream is a header whose low bits hold the destination node ID. The switch XORs that ID with its own `nodeId`. If the two are equal, the stream belongs to this node: the header is absorbed and the rest of the stream goes out on port 0. If they differ, the highest bit where they differ indexes a small direction table. Any free link port of that direction can then carry the stream, and the header is forwarded as the stream's first token.

Once a route is set, the switch is circuit-switched. Tokens pass straight from the input to the chosen output, and the output's ready signal flows straight back to the input. The route stays in place until a control token carrying the end-of-stream code has been transferred. After that, the output is free and the next token on that input is treated as a new header.

A header that finds no free link of its direction waits at the input with ready low. Headers that compete for outputs are served in a rotating order.

Top module: `dimroute_switch`

## Requirements
- R1: After reset no output is valid, no input is ready and every route is idle, including inputs that present a token at reset release.
- R2: A header whose low ID bits equal `nodeId` is consumed in the cycle its grant is made: input ready is high and no output is valid. The header is never forwarded. Every later token of that stream appears on output 0.
- R3: On a mismatch, the table entry used is the position of the most significant differing bit, with bit ID_W-1 examined first. Differing bits below that position have no effect on the route.
- R4: The direction table has one entry per ID bit and resets to all zeros (direction 0). A write with `cfgWe` high stores `cfgDir` at `cfgAddr` on the clock edge, and a header presented after that edge routes with the new value.
- R5: Link output o (1..NUM_LINKS) serves the direction held in `LINK_DIR[(o-1)*DIR_W +: DIR_W]`. The default assignment is link 1 to direction 0, links 2 and 3 to direction 1, and link 4 to direction 2. A stream takes the lowest-numbered free output of its direction, and no input ever holds more than one output.
- R6: A header that meets a free output is granted at the next clock edge. The header appears on that output in the following cycle, and no output is valid during the grant cycle. After that, tokens pass combinationally.
- R7: Data tokens, and control tokens whose data differs from EOP_CODE (default 16'h0001), keep the route unchanged.
- R8: A control token with data equal to EOP_CODE is forwarded and then releases the route at the edge that transfers it. Once released, the input no longer drives any output, and its next token is taken as a header.
- R9: If no free output exists for the header's direction, the input's ready stays low and the header reaches no output. This includes a direction with no links at all. The header is granted in the cycle after a suitable output frees or the table is rewritten.
- R10: Within a cycle, idle requesting inputs are visited starting from a rotating pointer, and each takes an output before those visited after it. The pointer is 0 after reset. After any cycle with grants, it moves to the input following the first input granted.
- R11: A routed input's ready equals the ready of its output. A token held while that ready is low stays on the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nodeId | input | ID_W | This node's own ID |
| cfgWe | input | 1 | Direction table write strobe |
| cfgAddr | input | $clog2(ID_W) | Table entry (bit position) to write |
| cfgDir | input | DIR_W | Direction value to store |
| inValid | input | NUM_LINKS+1 | Token valid per input, bit 0 is local |
| inCtrl | input | NUM_LINKS+1 | Control flag per input token |
| inData | input | (NUM_LINKS+1)*DATA_W | Token data per input, input i in slice i |
| inReady | output | NUM_LINKS+1 | Token accepted per input |
| outValid | output | NUM_LINKS+1 | Token valid per output, bit 0 is local |
| outCtrl | output | NUM_LINKS+1 | Control flag per output token |
| outData | output | (NUM_LINKS+1)*DATA_W | Token data per output |
| outReady | input | NUM_LINKS+1 | Downstream ready per output |

## Verification
A remote header shows up on its output one cycle after it is presented on a free route, because the grant edge stands between them. A local header is absorbed during that grant cycle itself. Once a route exists, tokens and ready signals pass with no register in the path. For this reason the bench settles the inputs just after the falling edge, checks the same-cycle results one time unit later, and checks grant and release effects only after the next rising edge. A table write, an end-of-stream transfer, and a stalled header's later grant each take one edge, followed by a second edge before the header becomes visible. The checks sample at those cycles exactly.

// File: rtl/dimroute_pkg.sv
package dimroute_pkg;
  localparam int IDX_W = 4;
  localparam int MAX_PORTS = 1 << IDX_W;

  typedef logic [IDX_W-1:0] portIdx_t;

  // ownership of one output, driven by control
  typedef struct packed {
    logic     busy;
    portIdx_t src;
  } outRoute_t;

  // per-input route state plus header-drop strobe
  typedef struct packed {
    logic     conn;
    portIdx_t sel;
    logic     drop;
  } inRoute_t;
endpackage

// File: rtl/dimroute_dp.sv
module dimroute_dp
  import dimroute_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ID_W      = 16,
  parameter int DATA_W    = 16,
  parameter int DIR_W     = 2,
  parameter logic [(NUM_PORTS-1)*DIR_W-1:0] LINK_DIR = '0,
  parameter logic [DATA_W-1:0] EOP_CODE = 1,
  localparam int ADDR_W = $clog2(ID_W)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ID_W-1:0]             nodeId,
  input  logic                        cfgWe,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [DIR_W-1:0]            cfgDir,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS-1:0]        inCtrl,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic [NUM_PORTS-1:0]        outValid,
  output logic [NUM_PORTS-1:0]        outCtrl,
  output logic [NUM_PORTS*DATA_W-1:0] outData,
  input  logic [NUM_PORTS-1:0]        outReady,
  input  outRoute_t                   outRoute [NUM_PORTS],
  input  inRoute_t                    inRoute  [NUM_PORTS],
  output logic [NUM_PORTS-1:0]        candMask [NUM_PORTS],
  output logic [NUM_PORTS-1:0]        xferEop
);

  logic [DIR_W-1:0]  dirTable [ID_W];
  logic [ID_W-1:0]   diffVec  [NUM_PORTS];
  logic [ADDR_W-1:0] hiBit    [NUM_PORTS];
  logic [DIR_W-1:0]  dirSel   [NUM_PORTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < ID_W; b++) dirTable[b] <= '0;
    end else if (cfgWe) begin
      dirTable[cfgAddr] <= cfgDir;
    end
  end

  // header decode: highest mismatching bit -> direction -> candidate outputs
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      diffVec[i] = inData[i*DATA_W +: ID_W] ^ nodeId;
      hiBit[i]   = '0;
      for (int b = 0; b < ID_W; b++) begin
        if (diffVec[i][b]) hiBit[i] = ADDR_W'(b);
      end
      dirSel[i]   = dirTable[hiBit[i]];
      candMask[i] = '0;
      if (diffVec[i] == '0) begin
        candMask[i][0] = 1'b1;
      end else begin
        for (int o = 1; o < NUM_PORTS; o++) begin
          candMask[i][o] = (LINK_DIR[(o-1)*DIR_W +: DIR_W] == dirSel[i]);
        end
      end
    end
  end

  // crossbar: output side
  always_comb begin
    outValid = '0;
    outCtrl  = '0;
    outData  = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (outRoute[o].busy && outRoute[o].src == portIdx_t'(i)) begin
          outValid[o]                = inValid[i];
          outCtrl[o]                 = inCtrl[i];
          outData[o*DATA_W +: DATA_W] = inData[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  // crossbar: ready side
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      inReady[i] = inRoute[i].drop;
      if (inRoute[i].conn) begin
        for (int o = 0; o < NUM_PORTS; o++) begin
          if (inRoute[i].sel == portIdx_t'(o)) inReady[i] = outReady[o];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      xferEop[i] = inRoute[i].conn && inValid[i] && inReady[i] && inCtrl[i]
                   && (inData[i*DATA_W +: DATA_W] == EOP_CODE);
    end
  end

endmodule

// File: rtl/dimroute_ctrl.sv
module dimroute_ctrl
  import dimroute_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] inValid,
  input  logic [NUM_PORTS-1:0] candMask [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] xferEop,
  output outRoute_t            outRoute [NUM_PORTS],
  output inRoute_t             inRoute  [NUM_PORTS]
);

  logic [NUM_PORTS-1:0] outBusy;
  logic [NUM_PORTS-1:0] inConn;
  portIdx_t             outSrc   [NUM_PORTS];
  portIdx_t             inSel    [NUM_PORTS];
  portIdx_t             rrPtr;
  portIdx_t             rrNext;
  logic [NUM_PORTS-1:0] grant;
  portIdx_t             grantOut [NUM_PORTS];

  // rotating allocation: each idle requester takes its lowest free candidate
  always_comb begin
    logic [NUM_PORTS-1:0] taken;
    logic                 anyGrant;
    int                   idx;
    taken    = outBusy;
    anyGrant = 1'b0;
    rrNext   = rrPtr;
    grant    = '0;
    for (int i = 0; i < NUM_PORTS; i++) grantOut[i] = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_PORTS) idx = idx - NUM_PORTS;
      if (inValid[idx] && !inConn[idx]) begin
        for (int o = 0; o < NUM_PORTS; o++) begin
          if (!grant[idx] && candMask[idx][o] && !taken[o]) begin
            grant[idx]    = 1'b1;
            grantOut[idx] = portIdx_t'(o);
            taken[o]      = 1'b1;
          end
        end
        if (grant[idx] && !anyGrant) begin
          anyGrant = 1'b1;
          rrNext   = portIdx_t'((idx + 1) % NUM_PORTS);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBusy <= '0;
      inConn  <= '0;
      rrPtr   <= '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        outSrc[i] <= '0;
        inSel[i]  <= '0;
      end
    end else begin
      rrPtr <= rrNext;
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (xferEop[i]) begin
          inConn[i] <= 1'b0;
          for (int o = 0; o < NUM_PORTS; o++) begin
            if (inSel[i] == portIdx_t'(o)) outBusy[o] <= 1'b0;
          end
        end
      end
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (grant[i]) begin
          inConn[i] <= 1'b1;
          inSel[i]  <= grantOut[i];
          for (int o = 0; o < NUM_PORTS; o++) begin
            if (grantOut[i] == portIdx_t'(o)) begin
              outBusy[o] <= 1'b1;
              outSrc[o]  <= portIdx_t'(i);
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      outRoute[i].busy = outBusy[i];
      outRoute[i].src  = outSrc[i];
      inRoute[i].conn  = inConn[i];
      inRoute[i].sel   = inSel[i];
      inRoute[i].drop  = grant[i] && (grantOut[i] == '0);
    end
  end

endmodule

// File: rtl/dimroute_switch.sv
module dimroute_switch
  import dimroute_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int ID_W      = 16,
  parameter int DATA_W    = 16,
  parameter int DIR_W     = 2,
  parameter logic [NUM_LINKS*DIR_W-1:0] LINK_DIR = {2'd2, 2'd1, 2'd1, 2'd0},
  parameter logic [DATA_W-1:0] EOP_CODE = 16'h0001,
  localparam int NUM_PORTS = NUM_LINKS + 1,
  localparam int ADDR_W    = $clog2(ID_W)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ID_W-1:0]             nodeId,
  input  logic                        cfgWe,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [DIR_W-1:0]            cfgDir,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS-1:0]        inCtrl,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic [NUM_PORTS-1:0]        outValid,
  output logic [NUM_PORTS-1:0]        outCtrl,
  output logic [NUM_PORTS*DATA_W-1:0] outData,
  input  logic [NUM_PORTS-1:0]        outReady
);

  outRoute_t            outRoute [NUM_PORTS];
  inRoute_t             inRoute  [NUM_PORTS];
  logic [NUM_PORTS-1:0] candMask [NUM_PORTS];
  logic [NUM_PORTS-1:0] xferEop;

  dimroute_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .candMask (candMask),
    .xferEop  (xferEop),
    .outRoute (outRoute),
    .inRoute  (inRoute)
  );

  dimroute_dp #(
    .NUM_PORTS (NUM_PORTS),
    .ID_W      (ID_W),
    .DATA_W    (DATA_W),
    .DIR_W     (DIR_W),
    .LINK_DIR  (LINK_DIR),
    .EOP_CODE  (EOP_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nodeId   (nodeId),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgDir   (cfgDir),
    .inValid  (inValid),
    .inCtrl   (inCtrl),
    .inData   (inData),
    .inReady  (inReady),
    .outValid (outValid),
    .outCtrl  (outCtrl),
    .outData  (outData),
    .outReady (outReady),
    .outRoute (outRoute),
    .inRoute  (inRoute),
    .candMask (candMask),
    .xferEop  (xferEop)
  );

endmodule

// File: rtl/dimroute_chk.sv
module dimroute_chk
  import dimroute_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 16,
  parameter logic [DATA_W-1:0] EOP_CODE = 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        inValid,
  input logic [NUM_PORTS-1:0]        inCtrl,
  input logic [NUM_PORTS*DATA_W-1:0] inData,
  input logic [NUM_PORTS-1:0]        inReady,
  input logic [NUM_PORTS-1:0]        outValid,
  input outRoute_t                   outRoute [NUM_PORTS],
  input inRoute_t                    inRoute  [NUM_PORTS]
);

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
    logic                 eopHs;
    logic [NUM_PORTS-1:0] owned;
    assign eopHs = inValid[gi] && inReady[gi] && inCtrl[gi]
                   && (inData[gi*DATA_W +: DATA_W] == EOP_CODE);
    always_comb begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        owned[o] = outRoute[o].busy && (outRoute[o].src == portIdx_t'(gi));
      end
    end

    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(owned));

    // R7
    route_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      inRoute[gi].conn && !eopHs |=> inRoute[gi].conn && $stable(inRoute[gi].sel));

    // R8
    eop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
      inRoute[gi].conn && eopHs |=> !inRoute[gi].conn);

    // R2
    local_absorb_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inRoute[gi].conn && inValid[gi] && inReady[gi] |=> inRoute[gi].conn && inRoute[gi].sel == '0);
  end

  for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
    // R6
    valid_has_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[go] |-> outRoute[go].busy);
  end

endmodule

bind dimroute_switch dimroute_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W),
  .EOP_CODE  (EOP_CODE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inCtrl   (inCtrl),
  .inData   (inData),
  .inReady  (inReady),
  .outValid (outValid),
  .outRoute (outRoute),
  .inRoute  (inRoute)
);

// File: tb/sim_dimroute_switch.sv
module sim_dimroute_switch;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int DW = 16;
  localparam logic [15:0] NODE = 16'hA5C3;
  localparam logic [15:0] EOP  = 16'h0001;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgAddr = '0;
  logic [1:0]    cfgDir = '0;
  logic [NP-1:0] inValid = '0, inCtrl = '0, inReady, outValid, outCtrl;
  logic [NP-1:0] outReady = '1;
  logic [NP*DW-1:0] inData = '0, outData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dimroute_switch u0 (
    .clk(clk), .rstN(rstN), .nodeId(NODE),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgDir(cfgDir),
    .inValid(inValid), .inCtrl(inCtrl), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outCtrl(outCtrl), .outData(outData), .outReady(outReady)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic setTok(int i, bit c, logic [15:0] d);
    inValid[i] = 1'b1;
    inCtrl[i]  = c;
    inData[i*DW +: DW] = d;
  endtask

  task automatic clrTok(int i);
    inValid[i] = 1'b0;
    inCtrl[i]  = 1'b0;
    inData[i*DW +: DW] = '0;
  endtask

  function automatic logic [15:0] outAt(int o);
    return outData[o*DW +: DW];
  endfunction

  // default link assignment: dir0->1, dir1->2,3, dir2->4
  function automatic int firstLink(int d);
    return (d == 0) ? 1 : (d == 1) ? 2 : 4;
  endfunction

  task automatic doReset();
    inValid = '0; inCtrl = '0; inData = '0; outReady = '1; cfgWe = 1'b0;
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic programTable();
    for (int b = 0; b < 16; b++) begin
      cfgWe = 1'b1; cfgAddr = 4'(b); cfgDir = 2'(b % 3);
      tick();
    end
    cfgWe = 1'b0;
  endtask

  task automatic runStream(int src, logic [15:0] dest, int expOut, string req);
    logic [15:0] pay;
    pay = 16'hD000 | 16'(src << 8) | dest[3:0];
    setTok(src, 1'b0, dest); #1;
    if (expOut == 0) begin
      check({req, " local header absorbed"}, 32'(inReady[src]), 1);
      check({req, " local header not forwarded"}, 32'(outValid), 0);
    end else begin
      check("R6 grant cycle idle", 32'(outValid), 0);
      check("R6 not ready before grant", 32'(inReady[src]), 0);
    end
    tick();
    if (expOut != 0) begin
      check({req, " header output"}, 32'(outValid), 32'(1 << expOut));
      check({req, " header data"}, 32'(outAt(expOut)), 32'(dest));
      tick();
    end
    setTok(src, 1'b0, pay); #1;
    check({req, " payload output"}, 32'(outValid), 32'(1 << expOut));
    check({req, " payload data"}, 32'(outAt(expOut)), 32'(pay));
    tick();
    setTok(src, 1'b1, 16'h0007); #1;
    check("R7 other ctrl keeps route", {31'd0, outValid[expOut] & outCtrl[expOut]}, 1);
    tick();
    setTok(src, 1'b1, EOP); #1;
    check("R8 eop forwarded", 32'(outAt(expOut)), 32'(EOP));
    tick();
    clrTok(src); #1;
    check("R8 released no output", 32'(outValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] dest;
    @(negedge clk); #1;
    doReset();
    // R1
    check("R1 no output valid", 32'(outValid), 0);
    check("R1 no input ready", 32'(inReady), 0);
    setTok(3, 1'b0, 16'h1234); #1;
    check("R1 no output while idle route", 32'(outValid), 0);
    clrTok(3);

    // R4 reset default: every entry is direction 0 -> link 1
    runStream(0, NODE ^ 16'h8000, 1, "R4");

    programTable();
    // R2 / R3 sweep: every source, every mismatch position
    for (int s = 0; s < NP; s++) begin
      runStream(s, NODE, 0, "R2");
      for (int b = 0; b < 16; b++) begin
        dest = NODE ^ 16'(1 << b) ^ ((16'h5A5A ^ 16'(s)) & 16'((1 << b) - 1));
        runStream(s, dest, firstLink(b % 3), "R3");
      end
    end

    // R4 reset clears table: bit 8 would be dir2 if programmed
    doReset();
    runStream(1, NODE ^ 16'h0100, 1, "R4");
    doReset();
    programTable();

    // R5 / R9: three requesters on direction 1 (links 2,3), pointer 0
    setTok(0, 1'b0, NODE ^ 16'h0010);
    setTok(1, 1'b0, NODE ^ 16'h0011);
    setTok(2, 1'b0, NODE ^ 16'h0012);
    #1;
    check("R6 grant cycle idle", 32'(outValid), 0);
    tick();
    check("R5 lowest link to first", 32'(outAt(2)), 32'(NODE ^ 16'h0010));
    check("R5 next link to second", 32'(outAt(3)), 32'(NODE ^ 16'h0011));
    check("R9 third stalls", 32'(inReady[2]), 0);
    check("R9 only two outputs", 32'(outValid), 32'h0C);
    tick();
    setTok(0, 1'b1, EOP);
    setTok(1, 1'b0, 16'h1111);
    tick();
    clrTok(0); #1;
    check("R8 link freed", 32'(outValid[2]), 0);
    check("R9 still waiting", 32'(inReady[2]), 0);
    tick();
    check("R9 granted after free", 32'(outAt(2)), 32'(NODE ^ 16'h0012));
    check("R7 other route untouched", 32'(outAt(3)), 32'h1111);
    tick();
    setTok(1, 1'b1, EOP);
    setTok(2, 1'b1, EOP);
    tick();
    clrTok(1); clrTok(2);
    tick();

    // R10: pointer now 3; inputs 1 and 3 contend for link 1
    setTok(1, 1'b0, NODE ^ 16'h0009);
    setTok(3, 1'b0, NODE ^ 16'h000B);
    tick();
    check("R10 rotation favours input 3", 32'(outAt(1)), 32'(NODE ^ 16'h000B));
    check("R10 input 1 waits", 32'(inReady[1]), 0);
    tick();
    setTok(3, 1'b1, EOP);
    tick();
    clrTok(3);
    tick();
    check("R9 waiter served", 32'(outAt(1)), 32'(NODE ^ 16'h0009));
    tick();
    setTok(1, 1'b1, EOP);
    tick();
    clrTok(1);
    tick();
    // pointer now 2; inputs 0 and 4 contend
    setTok(0, 1'b0, NODE ^ 16'h0008);
    setTok(4, 1'b0, NODE ^ 16'h000C);
    tick();
    check("R10 rotation favours input 4", 32'(outAt(1)), 32'(NODE ^ 16'h000C));
    check("R10 input 0 waits", 32'(inReady[0]), 0);
    tick();
    setTok(4, 1'b1, EOP);
    tick();
    clrTok(4);
    tick();
    check("R10 input 0 later", 32'(outAt(1)), 32'(NODE ^ 16'h0008));
    tick();
    setTok(0, 1'b1, EOP);
    tick();
    clrTok(0);
    tick();

    // R9 / R4: direction without links, then table rewrite
    cfgWe = 1'b1; cfgAddr = 4'd14; cfgDir = 2'd3;
    tick();
    cfgWe = 1'b0;
    setTok(2, 1'b0, NODE ^ 16'h4000);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R9 no link direction stalls", 32'(inReady[2]), 0);
      check("R9 no link direction no output", 32'(outValid), 0);
    end
    cfgWe = 1'b1; cfgDir = 2'd2;
    tick();
    cfgWe = 1'b0; #1;
    check("R4 write edge then grant cycle", 32'(outValid), 0);
    tick();
    check("R4 new direction used", 32'(outAt(4)), 32'(NODE ^ 16'h4000));
    tick();
    setTok(2, 1'b1, EOP);
    tick();
    clrTok(2);
    tick();

    // R11 backpressure
    setTok(3, 1'b0, NODE ^ 16'h0004);
    tick();
    check("R5 bit2 to link 4", 32'(outValid), 32'h10);
    tick();
    setTok(3, 1'b0, 16'hBEEF);
    outReady[4] = 1'b0; #1;
    check("R11 ready follows output", 32'(inReady[3]), 0);
    tick();
    check("R11 token held", 32'(outAt(4)), 32'hBEEF);
    check("R11 still valid", 32'(outValid[4]), 1);
    outReady[4] = 1'b1; #1;
    check("R11 ready restored", 32'(inReady[3]), 1);
    tick();
    setTok(3, 1'b1, EOP);
    tick();
    clrTok(3); #1;
    check("R8 final release", 32'(outValid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule